// File: doc/BRIEF.md
# Nine-Bit Serial Configuration Target

This block is the configuration port of a display bridge. A host reaches it over a three-wire serial link that moves 9-bit words. The top bit of each word says whether the word is a command or data. A command word carries an 8-bit register address. Data words carry bytes, and a 16-bit register is written as a low byte followed by a high byte. A small bank of 16-bit registers holds the bridge settings, and the configuration register is brought out to the rest of the chip.

A register is read indirectly. The host arms a read by writing a fixed code into a read-control register. It then names the address to read. It then sends a trigger word, and the block shifts the 16-bit value back on MISO. A separate payload path accepts a counted run of bytes after a dedicated command and queues them in a byte FIFO. Downstream logic drains that FIFO through a valid/ready handshake.

The serial pins are sampled in the system clock domain through synchronizers. The host's serial clock must therefore run several times slower than the system clock.

Top module: `spi9_cfg_slave`

## Requirements
- R1: Words are 9 bits, sent MSB first in SPI mode 0 and sampled on the rising SCK edge while CSN is low. Bit 8 = 0 marks a command and bit 8 = 1 marks data; bits 7..0 carry the value. Raising CSN part-way through a word discards the bits already received.
- R2: A register write is a command word holding the address, then a data word with bits 7..0, then a data word with bits 15..8. A data word with no preceding valid command has no effect. A data word after a completed write also has no effect.
- R3: Addresses 0xB0..0xEB form the bank. 0xB0 always reads the identification value ID_VAL, and writes to it are discarded. 0xBF (payload command) and 0xC7 (error status) cannot be written. All other bank addresses store what is written. Writes outside the bank are discarded, and reads outside the bank return 0x0000.
- R4: A read is armed when register 0xD4 holds 0x00FA. The next command word then selects the address to read. A following command word with value 0xFA starts the reply: 16 bits, MSB first, each bit changing after a falling SCK edge. Register 0xD4 returns to 0x0000 once the reply starts. Without arming, MISO stays 0.
- R5: Output cfg_o follows register 0xB7 and resets to CFG_DEFAULT (0x0300).
- R6: A command word 0xBF starts a payload run. Its length is the value held in 0xBC. Exactly that many following data bytes enter the FIFO in order. Later data words are ignored. A length of 0 queues nothing.
- R7: The FIFO holds 16 bytes. Payload bytes that arrive while it is full are dropped, and bit 0 of register 0xC7 is set and stays set.
- R8: Writing 0x0100 to 0xC0 returns every register to its default, clears the error bit and empties the FIFO.
- R9: While pl_valid_o is high and pl_ready_i is low, pl_valid_o and pl_data_o hold. A byte leaves the FIFO on a cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from host |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial read-back data to host |
| cfg_o | output | 16 | Contents of the configuration register 0xB7 |
| pl_data_o | output | 8 | Payload byte at FIFO head |
| pl_valid_o | output | 1 | Payload byte available |
| pl_ready_i | input | 1 | Downstream accepts the payload byte |

## Verification
Faults in the sequencer appear at the ports within one word. A lost or stuck byte-pair state moves a register value into the wrong byte lane, or onto the wrong address, and the next read-back shows it. A wrong payload counter shows up as extra or missing bytes at the FIFO head before the following command. A bad bit counter in the shifter misframes every later word, so an address sweep that writes then reads the whole bank around its edges exposes it at once. A fault in the error flag or the soft reset is visible on the next read of 0xC7 or on cfg_o.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
  localparam logic [7:0] A_FIRST  = 8'hB0;
  localparam logic [7:0] A_LAST   = 8'hEB;
  localparam logic [7:0] A_ID     = 8'hB0;
  localparam logic [7:0] A_CFG    = 8'hB7;
  localparam logic [7:0] A_PKSZ   = 8'hBC;
  localparam logic [7:0] A_PKDROP = 8'hBF;
  localparam logic [7:0] A_OPCTL  = 8'hC0;
  localparam logic [7:0] A_ERR    = 8'hC7;
  localparam logic [7:0] A_RDCTL  = 8'hD4;
  localparam logic [7:0] RD_MAGIC = 8'hFA;
  localparam logic [15:0] SRST_VAL = 16'h0100;
  localparam int NREG = int'(A_LAST) - int'(A_FIRST) + 1;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LO,
    SQ_HI,
    SQ_PAY,
    SQ_RDW
  } seq_e;

  function automatic logic in_bank(input logic [7:0] a);
    return (a >= A_FIRST) && (a <= A_LAST);
  endfunction

  function automatic logic writable(input logic [7:0] a);
    return in_bank(a) && (a != A_ID) && (a != A_ERR) && (a != A_PKDROP);
  endfunction
endpackage

// File: rtl/spi9_shift.sv
module spi9_shift #(
  parameter int SYNC = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sck_i,
  input  logic        csn_i,
  input  logic        mosi_i,
  input  logic        tx_load_i,
  input  logic [15:0] tx_data_i,
  output logic [8:0]  word_o,
  output logic        word_vld_o,
  output logic        miso_o,
  output logic        busy_o
);
  localparam int WBITS = 9;
  localparam int CW    = $clog2(WBITS);
  localparam int TXB   = 16;
  localparam int TCW   = $clog2(TXB);

  logic [SYNC-1:0] sck_p, cs_p, mo_p;
  logic sck_q;
  logic sck_s, cs_s, mo_s, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_p <= '0;
      cs_p  <= '1;
      mo_p  <= '0;
      sck_q <= 1'b0;
    end else begin
      sck_p <= {sck_p[SYNC-2:0], sck_i};
      cs_p  <= {cs_p[SYNC-2:0], csn_i};
      mo_p  <= {mo_p[SYNC-2:0], mosi_i};
      sck_q <= sck_p[SYNC-1];
    end
  end

  assign sck_s = sck_p[SYNC-1];
  assign cs_s  = cs_p[SYNC-1];
  assign mo_s  = mo_p[SYNC-1];
  assign rise  = sck_s & ~sck_q & ~cs_s;
  assign fall  = ~sck_s & sck_q & ~cs_s;

  logic [WBITS-2:0] rx_sr;
  logic [CW-1:0]    bit_cnt;
  logic [15:0]      tx_sr, tx_buf;
  logic             tx_pend, tx_act;
  logic [TCW-1:0]   tx_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sr      <= '0;
      bit_cnt    <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
      tx_sr      <= '0;
      tx_buf     <= '0;
      tx_pend    <= 1'b0;
      tx_act     <= 1'b0;
      tx_cnt     <= '0;
    end else begin
      word_vld_o <= 1'b0;
      if (tx_load_i) begin
        tx_buf  <= tx_data_i;
        tx_pend <= 1'b1;
      end
      if (cs_s) begin
        bit_cnt <= '0;
        tx_pend <= 1'b0;
        tx_act  <= 1'b0;
        tx_cnt  <= '0;
      end else if (rise) begin
        if (tx_act) begin
          if (tx_cnt == TCW'(TXB - 1)) begin
            tx_act <= 1'b0;
            tx_cnt <= '0;
          end else begin
            tx_cnt <= tx_cnt + 1'b1;
          end
        end else if (!tx_pend) begin
          rx_sr <= {rx_sr[WBITS-3:0], mo_s};
          if (bit_cnt == CW'(WBITS - 1)) begin
            word_o     <= {rx_sr, mo_s};
            word_vld_o <= 1'b1;
            bit_cnt    <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end else if (fall) begin
        if (tx_pend) begin
          tx_sr   <= tx_buf;
          tx_act  <= 1'b1;
          tx_pend <= 1'b0;
          tx_cnt  <= '0;
        end else if (tx_act) begin
          tx_sr <= {tx_sr[14:0], 1'b0};
        end
      end
    end
  end

  assign miso_o = tx_act & tx_sr[15];
  assign busy_o = tx_pend | tx_act;
endmodule

// File: rtl/spi9_regs.sv
module spi9_regs
  import spi9_pkg::*;
#(
  parameter logic [15:0] ID_VAL      = 16'h5A17,
  parameter logic [15:0] CFG_DEFAULT = 16'h0300
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        srst_i,
  input  logic        we_i,
  input  logic [7:0]  waddr_i,
  input  logic [15:0] wdata_i,
  input  logic [7:0]  raddr_i,
  input  logic [15:0] err_i,
  output logic [15:0] rdata_o,
  output logic [15:0] cfg_o,
  output logic [15:0] pksz_o,
  output logic [15:0] rdctl_o
);
  localparam int IW    = $clog2(NREG);
  localparam int NSLOT = 1 << IW;

  logic [15:0] q [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [7:0] AD = A_FIRST + 8'(i);
    if (i >= NREG || AD == A_ID || AD == A_ERR || AD == A_PKDROP) begin : g_none
      assign q[i] = '0;
    end else begin : g_rw
      localparam logic [15:0] DEF = (AD == A_CFG) ? CFG_DEFAULT : 16'h0000;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     q[i] <= DEF;
        else if (srst_i)                 q[i] <= DEF;
        else if (we_i && waddr_i == AD) q[i] <= wdata_i;
      end
    end
  end

  logic [IW-1:0] roff;
  assign roff = IW'(raddr_i - A_FIRST);

  always_comb begin
    rdata_o = '0;
    if (in_bank(raddr_i)) begin
      if (raddr_i == A_ID)       rdata_o = ID_VAL;
      else if (raddr_i == A_ERR) rdata_o = err_i;
      else                       rdata_o = q[roff];
    end
  end

  assign cfg_o   = q[int'(A_CFG - A_FIRST)];
  assign pksz_o  = q[int'(A_PKSZ - A_FIRST)];
  assign rdctl_o = q[int'(A_RDCTL - A_FIRST)];
endmodule

// File: rtl/spi9_fifo.sv
module spi9_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  output logic [W-1:0] dout_o,
  output logic         valid_o,
  input  logic         ready_i
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic do_push, do_pop;

  assign full_o  = (cnt == (AW+1)'(DEPTH));
  assign valid_o = (cnt != '0);
  assign dout_o  = mem[rp];
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = valid_o & ready_i & ~flush_i;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush_i) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi9_cfg_slave.sv
module spi9_cfg_slave
  import spi9_pkg::*;
#(
  parameter logic [15:0] ID_VAL      = 16'h5A17,
  parameter logic [15:0] CFG_DEFAULT = 16'h0300,
  parameter int          FIFO_DEPTH  = 16,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sck_i,
  input  logic        csn_i,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic [15:0] cfg_o,
  output logic [7:0]  pl_data_o,
  output logic        pl_valid_o,
  input  logic        pl_ready_i
);
  logic [8:0]  word;
  logic        word_vld, tx_busy, tx_load;
  logic        is_cmd, is_dat, armed;
  logic [7:0]  byt;
  logic [15:0] rdata, pksz, rdctl;
  seq_e        st;
  logic [7:0]  cur_addr, rd_addr, lo_q;
  logic [15:0] remaining;
  logic        ovf, full, push, drop, srst, we;
  logic [7:0]  waddr;
  logic [15:0] wdata;

  spi9_shift #(.SYNC(SYNC_STAGES)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sck_i),
    .csn_i      (csn_i),
    .mosi_i     (mosi_i),
    .tx_load_i  (tx_load),
    .tx_data_i  (rdata),
    .word_o     (word),
    .word_vld_o (word_vld),
    .miso_o     (miso_o),
    .busy_o     (tx_busy)
  );

  assign is_cmd  = word_vld & ~word[8];
  assign is_dat  = word_vld & word[8];
  assign byt     = word[7:0];
  assign armed   = (rdctl == {8'h00, RD_MAGIC});
  assign tx_load = is_cmd && (st == SQ_RDW) && (byt == RD_MAGIC);

  // completed pair, or clearing the read arm when a reply starts
  assign we    = (is_dat && st == SQ_HI) || tx_load;
  assign waddr = tx_load ? A_RDCTL : cur_addr;
  assign wdata = tx_load ? 16'h0000 : {byt, lo_q};
  assign srst  = is_dat && (st == SQ_HI) && (cur_addr == A_OPCTL) && ({byt, lo_q} == SRST_VAL);

  assign push = is_dat && (st == SQ_PAY);
  assign drop = push && full;

  spi9_regs #(.ID_VAL(ID_VAL), .CFG_DEFAULT(CFG_DEFAULT)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (srst),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (rd_addr),
    .err_i   ({15'b0, ovf}),
    .rdata_o (rdata),
    .cfg_o   (cfg_o),
    .pksz_o  (pksz),
    .rdctl_o (rdctl)
  );

  spi9_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (srst),
    .push_i  (push),
    .din_i   (byt),
    .full_o  (full),
    .dout_o  (pl_data_o),
    .valid_o (pl_valid_o),
    .ready_i (pl_ready_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovf <= 1'b0;
    else if (srst)    ovf <= 1'b0;
    else if (drop)    ovf <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= SQ_IDLE;
      cur_addr  <= '0;
      rd_addr   <= '0;
      lo_q      <= '0;
      remaining <= '0;
    end else if (is_cmd) begin
      if (tx_load) begin
        st <= SQ_IDLE;
      end else if (armed) begin
        rd_addr <= byt;
        st      <= SQ_RDW;
      end else if (byt == A_PKDROP) begin
        remaining <= pksz;
        st        <= (pksz == '0) ? SQ_IDLE : SQ_PAY;
      end else if (writable(byt)) begin
        cur_addr <= byt;
        st       <= SQ_LO;
      end else begin
        st <= SQ_IDLE;
      end
    end else if (is_dat) begin
      case (st)
        SQ_LO: begin
          lo_q <= byt;
          st   <= SQ_HI;
        end
        SQ_HI: st <= SQ_IDLE;
        SQ_PAY: begin
          remaining <= remaining - 1'b1;
          if (remaining == 16'd1) st <= SQ_IDLE;
        end
        default: st <= st;
      endcase
    end
  end
endmodule

// File: rtl/spi9_cfg_chk.sv
module spi9_cfg_chk #(
  parameter logic [15:0] CFG_DEFAULT = 16'h0300
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pl_valid_o,
  input logic        pl_ready_i,
  input logic [7:0]  pl_data_o,
  input logic [15:0] cfg_o,
  input logic        ovf,
  input logic        drop,
  input logic        srst,
  input logic        tx_load,
  input logic        tx_busy,
  input logic        word_vld
);
  a_r9_hold_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_valid_o && !pl_ready_i && !srst) |=> (pl_valid_o && $stable(pl_data_o)));

  a_r7_drop_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop && !srst) |=> ovf);

  a_r7_sticky_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !srst) |=> ovf);

  a_r8_soft_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (cfg_o == CFG_DEFAULT && !ovf && !pl_valid_o));

  a_r4_load_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load |-> !tx_busy);

  a_r4_no_rx_in_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy |-> !word_vld);
endmodule

bind spi9_cfg_slave spi9_cfg_chk #(.CFG_DEFAULT(CFG_DEFAULT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pl_valid_o (pl_valid_o),
  .pl_ready_i (pl_ready_i),
  .pl_data_o  (pl_data_o),
  .cfg_o      (cfg_o),
  .ovf        (ovf),
  .drop       (drop),
  .srst       (srst),
  .tx_load    (tx_load),
  .tx_busy    (tx_busy),
  .word_vld   (word_vld)
);

// File: tb/sim_spi9_cfg_slave.sv
`timescale 1ns/1ps
module sim_spi9_cfg_slave;
  localparam logic [15:0] ID  = 16'h5A17;
  localparam logic [15:0] DEF = 16'h0300;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, ready = 1'b0;
  logic miso, pl_valid;
  logic [15:0] cfg;
  logic [7:0] pl_data;
  int nvec = 0, nfail = 0;

  always #2.5 clk = ~clk;

  spi9_cfg_slave #(.ID_VAL(ID), .CFG_DEFAULT(DEF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .cfg_o(cfg), .pl_data_o(pl_data), .pl_valid_o(pl_valid),
    .pl_ready_i(ready)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic shift9(input logic [8:0] w);
    for (int i = 8; i >= 0; i--) begin
      mosi = w[i];
      #HALF sck = 1'b1;
      #HALF sck = 1'b0;
    end
  endtask

  task automatic send_word(input logic [8:0] w);
    csn = 1'b0;
    #HALF;
    shift9(w);
    #HALF csn = 1'b1;
    #(4*HALF);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [15:0] v);
    send_word({1'b0, a});
    send_word({1'b1, v[7:0]});
    send_word({1'b1, v[15:8]});
  endtask

  task automatic rd_tail(output logic [15:0] v);
    csn = 1'b0;
    #HALF;
    shift9({1'b0, 8'hFA});
    for (int j = 15; j >= 0; j--) begin
      #HALF v[j] = miso;
      sck = 1'b1;
      #HALF sck = 1'b0;
    end
    #HALF csn = 1'b1;
    #(4*HALF);
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [15:0] v);
    wr_reg(8'hD4, 16'h00FA);
    send_word({1'b0, a});
    rd_tail(v);
  endtask

  task automatic pop_chk(input string tag, input logic [7:0] exp);
    logic [7:0] first;
    @(negedge clk);
    chk({tag, " valid"}, 16'(pl_valid), 16'd1);
    first = pl_data;
    repeat (3) @(negedge clk);
    chk("R9 head held", 16'(pl_data), 16'(first));
    chk(tag, 16'(pl_data), 16'(exp));
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  function automatic logic [15:0] fval(input int a);
    return {8'(a) ^ 8'h5A, 8'(a) ^ 8'h3C};
  endfunction

  function automatic logic [15:0] sweep_exp(input int a);
    if (a < 'hB0 || a > 'hEB) return 16'h0000;
    if (a == 'hB0) return ID;
    if (a == 'hBF || a == 'hC7) return 16'h0000;
    if (a == 'hD4) return 16'h00FA;
    return fval(a);
  endfunction

  initial begin
    #(950_000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    #(10*HALF) rst_n = 1'b1;
    #(4*HALF);

    // reset state
    chk("R5 cfg reset", cfg, DEF);
    chk("R6 fifo empty at reset", 16'(pl_valid), 16'd0);
    chk("R4 miso idle", 16'(miso), 16'd0);
    rd_reg(8'hB0, v); chk("R3 id", v, ID);
    rd_reg(8'hC7, v); chk("R7 err clear", v, 16'h0000);

    // R2: orphan data words
    send_word(9'h1AA);
    send_word(9'h155);
    rd_reg(8'hB1, v); chk("R2 orphan data ignored", v, 16'h0000);
    chk("R2 orphan data no payload", 16'(pl_valid), 16'd0);

    // R2: extra byte after a complete pair
    wr_reg(8'hB1, 16'h1234);
    send_word(9'h1FF);
    rd_reg(8'hB1, v); chk("R2 pair order and trailing byte", v, 16'h1234);

    // R1: aborted partial word
    csn = 1'b0; #HALF;
    for (int i = 0; i < 4; i++) begin
      mosi = i[0];
      #HALF sck = 1'b1;
      #HALF sck = 1'b0;
    end
    #HALF csn = 1'b1; #(4*HALF);
    wr_reg(8'hB2, 16'hBEEF);
    rd_reg(8'hB2, v); chk("R1 partial word discarded", v, 16'hBEEF);

    // R5: configuration output
    wr_reg(8'hB7, 16'h0648);
    chk("R5 cfg follows", cfg, 16'h0648);
    rd_reg(8'hB7, v); chk("R4 msb-first reply", v, 16'h0648);

    // R4: unarmed read returns nothing
    send_word({1'b0, 8'hB7});
    rd_tail(v); chk("R4 unarmed miso", v, 16'h0000);

    // R3: sweep write then read over the bank and both edges
    for (int a = 'hAC; a <= 'hEF; a++) begin
      if (a != 'hBF) wr_reg(8'(a), fval(a));
    end
    chk("R5 cfg after sweep", cfg, fval('hB7));
    for (int a = 'hAC; a <= 'hEF; a++) begin
      rd_reg(8'(a), v);
      chk($sformatf("R3 addr %h", a), v, sweep_exp(a));
    end
    send_word({1'b0, 8'hD4});
    rd_tail(v); chk("R4 arm consumed", v, 16'h0000);

    // R8: soft reset
    wr_reg(8'hC0, 16'h0100);
    chk("R8 cfg default", cfg, DEF);
    rd_reg(8'hB1, v); chk("R8 reg default", v, 16'h0000);
    rd_reg(8'hC0, v); chk("R8 opctl default", v, 16'h0000);

    // R6: counted payload
    wr_reg(8'hBC, 16'd5);
    send_word({1'b0, 8'hBF});
    for (int k = 0; k < 7; k++) send_word({1'b1, 8'(8'h30 + k*7)});
    for (int k = 0; k < 5; k++) pop_chk($sformatf("R6 byte %0d", k), 8'(8'h30 + k*7));
    @(negedge clk); chk("R6 run length", 16'(pl_valid), 16'd0);
    wr_reg(8'hBC, 16'd0);
    send_word({1'b0, 8'hBF});
    send_word(9'h1EE);
    @(negedge clk); chk("R6 zero length", 16'(pl_valid), 16'd0);

    // R7: overflow
    wr_reg(8'hBC, 16'd20);
    send_word({1'b0, 8'hBF});
    for (int k = 0; k < 20; k++) send_word({1'b1, 8'(8'h80 + k*3)});
    rd_reg(8'hC7, v); chk("R7 overflow flag", v, 16'h0001);
    for (int k = 0; k < 16; k++) pop_chk($sformatf("R7 byte %0d", k), 8'(8'h80 + k*3));
    @(negedge clk); chk("R7 drops beyond depth", 16'(pl_valid), 16'd0);
    rd_reg(8'hC7, v); chk("R7 flag sticky", v, 16'h0001);

    // R8: soft reset clears the flag and FIFO
    wr_reg(8'hBC, 16'd2);
    send_word({1'b0, 8'hBF});
    send_word(9'h111);
    wr_reg(8'hC0, 16'h0100);
    @(negedge clk); chk("R8 fifo flushed", 16'(pl_valid), 16'd0);
    rd_reg(8'hC7, v); chk("R8 flag cleared", v, 16'h0000);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule